// File: doc/BRIEF.md
# Motor Drive Update and Failsafe Scheduler

This block decides when the drive levels staged for a set of motor channels move into the active output bank. It also decides how that bank and the rest of the system respond to a failsafe event. The inputs are a driver-enable register value, an update period in milliseconds, a self-clearing force-update register, a failsafe configuration byte, a one-millisecond tick and a failsafe input. The outputs are the active drive levels, a one-cycle update pulse, a set of one-cycle restart and port-reinitialise requests, and a running count of failsafe events.

A non-zero period N copies the staged levels into the bank on every Nth millisecond tick. A period of zero turns automatic copying off, so only the force register can cause a copy. The active outputs read zero unless the enable value is exactly 0x01. A failsafe event can zero the bank or leave it as it is, and it raises the requests selected by the configuration byte. PWM generation, the power stage and the register bus are outside this block.

Top module: `motor_update_sched`

## Requirements
- R1: After reset, the active levels are 0, the update pulse and all requests are low, the force register reads 0x00 and the failsafe count is 0.
- R2: With a period N > 0, the Nth millisecond tick after the count restarts loads the staged levels into the bank. `upd_pulse_o` is high for that one following cycle. Earlier ticks and cycles without a tick change nothing.
- R3: With a period of 0, no tick ever loads the bank or raises `upd_pulse_o`.
- R4: A write of 0x01 to the force register makes it read 0x01 for one cycle. At the next edge the bank loads, `upd_pulse_o` pulses and the register clears to 0x00. A write of any other value leaves it at 0x00 and causes no update.
- R5: Any change of the period value restarts the tick count from zero.
- R6: The active outputs show the bank only while the enable value is 0x01. Any other value drives all outputs to zero, and the bank is kept for when the enable value returns to 0x01.
- R7: A failsafe event is a rising edge of `fail_i`. If failsafe control bit 0 is 1, the event clears the bank to zero. If bit 0 is 0, the bank holds its levels.
- R8: Failsafe control bits 2:1 pick the restart request: 1 pulses `req_reboot_o`, 2 pulses `req_reenum_o`, and 0 or 3 pulses neither. The pulse lasts one cycle, in the cycle after the event edge.
- R9: Failsafe control bit 3 pulses `req_uport_o` and bit 4 pulses `req_eport_o` for one cycle after the event.
- R10: Each failsafe event raises `fs_count_o` by one, wrapping modulo 2^CNT_W. A level held high counts only once.
- R11: When a zeroing failsafe event and an update land on the same edge, the bank ends up zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_en_i | input | 8 | Driver-enable register value (0x01 = on) |
| rate_i | input | 8 | Update period in milliseconds, 0 = manual only |
| force_we_i | input | 1 | Write strobe for the force-update register |
| force_wdata_i | input | 8 | Data written to the force-update register |
| fs_ctrl_i | input | 8 | Failsafe configuration byte |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| fail_i | input | 1 | Failsafe condition input |
| stage_lvl_i | input | NUM_CH*LVL_W | Staged drive levels, channel 0 in the low bits |
| act_lvl_o | output | NUM_CH*LVL_W | Active drive levels |
| upd_pulse_o | output | 1 | One-cycle pulse after each bank load |
| force_reg_o | output | 8 | Read value of the force-update register |
| req_reboot_o | output | 1 | Reboot request pulse |
| req_reenum_o | output | 1 | Re-enumeration request pulse |
| req_uport_o | output | 1 | User-port reinitialise request pulse |
| req_eport_o | output | 1 | Expansion-port reinitialise request pulse |
| fs_count_o | output | CNT_W | Failsafe event count |

## Verification
The bank load caused by a tick, along with `upd_pulse_o`, can be seen one register after the edge that samples the Nth tick. A force write takes two edges to reach the bank: one to set the register and one to apply it. The failsafe requests, the count and any zeroing can be seen right after the edge that first samples `fail_i` high. The enable gating is combinational and shows in the same cycle. The bench drives inputs and samples outputs one time unit after each rising edge, so every expected value is compared at the exact edge the requirements name. It also checks that nothing changes on the cycles just before and just after.

// File: rtl/mupd_pkg.sv
package mupd_pkg;

    localparam int REG_W = 8;
    localparam logic [REG_W-1:0] FORCE_CODE  = 8'h01;
    localparam logic [REG_W-1:0] DRV_ON_CODE = 8'h01;

    typedef enum logic [1:0] {
        RST_NONE   = 2'd0,
        RST_REBOOT = 2'd1,
        RST_REENUM = 2'd2,
        RST_RSVD   = 2'd3
    } restart_e;

    typedef struct packed {
        logic     eport;
        logic     uport;
        restart_e restart;
        logic     zero_out;
    } fs_cfg_t;

    typedef struct packed {
        logic reboot;
        logic reenum;
        logic uport;
        logic eport;
    } fs_req_t;

    function automatic fs_cfg_t decode_fs(input logic [REG_W-1:0] raw);
        fs_cfg_t c;
        c.zero_out = raw[0];
        c.restart  = restart_e'(raw[2:1]);
        c.uport    = raw[3];
        c.eport    = raw[4];
        return c;
    endfunction

    function automatic fs_req_t cfg_to_req(input fs_cfg_t c);
        fs_req_t r;
        r.reboot = (c.restart == RST_REBOOT);
        r.reenum = (c.restart == RST_REENUM);
        r.uport  = c.uport;
        r.eport  = c.eport;
        return r;
    endfunction

endpackage

// File: rtl/mupd_period_timer.sv
module mupd_period_timer
    import mupd_pkg::*;
#(
    parameter int RATE_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              ms_tick_i,
    output logic              hit_o
);
    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] cnt_q;
    logic              rate_chg;
    logic              at_end;

    assign rate_chg = (rate_i != rate_q);
    assign at_end   = (cnt_q == rate_i - RATE_W'(1));
    assign hit_o    = ms_tick_i && !rate_chg && (rate_i != '0) && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
            cnt_q  <= '0;
        end else begin
            rate_q <= rate_i;
            if (rate_chg || rate_i == '0) begin
                cnt_q <= '0;
            end else if (ms_tick_i) begin
                cnt_q <= at_end ? '0 : cnt_q + RATE_W'(1);
            end
        end
    end
endmodule

// File: rtl/mupd_force_reg.sv
module mupd_force_reg
    import mupd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic             fire_o,
    output logic [REG_W-1:0] rd_o
);
    logic pend_q;

    assign fire_o = pend_q;
    assign rd_o   = pend_q ? FORCE_CODE : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (we_i) begin
            pend_q <= (wdata_i == FORCE_CODE);
        end else if (pend_q) begin
            pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/mupd_failsafe.sv
module mupd_failsafe
    import mupd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fail_i,
    input  logic [REG_W-1:0] ctrl_i,
    output logic             zero_o,
    output fs_req_t          req_o,
    output logic [CNT_W-1:0] count_o
);
    logic    fail_q;
    logic    event_w;
    fs_cfg_t cfg;

    assign cfg     = decode_fs(ctrl_i);
    assign event_w = fail_i && !fail_q;
    assign zero_o  = event_w && cfg.zero_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q  <= 1'b0;
            req_o   <= '0;
            count_o <= '0;
        end else begin
            fail_q <= fail_i;
            req_o  <= event_w ? cfg_to_req(cfg) : '0;
            if (event_w) begin
                count_o <= count_o + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/motor_update_sched.sv
module motor_update_sched
    import mupd_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int LVL_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [7:0]              drv_en_i,
    input  logic [7:0]              rate_i,
    input  logic                    force_we_i,
    input  logic [7:0]              force_wdata_i,
    input  logic [7:0]              fs_ctrl_i,
    input  logic                    ms_tick_i,
    input  logic                    fail_i,
    input  logic [NUM_CH*LVL_W-1:0] stage_lvl_i,
    output logic [NUM_CH*LVL_W-1:0] act_lvl_o,
    output logic                    upd_pulse_o,
    output logic [7:0]              force_reg_o,
    output logic                    req_reboot_o,
    output logic                    req_reenum_o,
    output logic                    req_uport_o,
    output logic                    req_eport_o,
    output logic [CNT_W-1:0]        fs_count_o
);
    localparam int BANK_W = NUM_CH * LVL_W;

    logic    tick_hit;
    logic    force_fire;
    logic    fs_zero;
    logic    load;
    logic    drv_on;
    fs_req_t req;
    logic [BANK_W-1:0] bank_q;

    mupd_period_timer #(.RATE_W(REG_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .rate_i    (rate_i),
        .ms_tick_i (ms_tick_i),
        .hit_o     (tick_hit)
    );

    mupd_force_reg u_force (
        .clk     (clk),
        .rst     (rst),
        .we_i    (force_we_i),
        .wdata_i (force_wdata_i),
        .fire_o  (force_fire),
        .rd_o    (force_reg_o)
    );

    mupd_failsafe #(.CNT_W(CNT_W)) u_fs (
        .clk     (clk),
        .rst     (rst),
        .fail_i  (fail_i),
        .ctrl_i  (fs_ctrl_i),
        .zero_o  (fs_zero),
        .req_o   (req),
        .count_o (fs_count_o)
    );

    assign load   = tick_hit || force_fire;
    assign drv_on = (drv_en_i == DRV_ON_CODE);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst || fs_zero) begin
                bank_q[ch*LVL_W +: LVL_W] <= '0;
            end else if (load) begin
                bank_q[ch*LVL_W +: LVL_W] <= stage_lvl_i[ch*LVL_W +: LVL_W];
            end
        end
        assign act_lvl_o[ch*LVL_W +: LVL_W] = drv_on ? bank_q[ch*LVL_W +: LVL_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) upd_pulse_o <= 1'b0;
        else     upd_pulse_o <= load;
    end

    assign req_reboot_o = req.reboot;
    assign req_reenum_o = req.reenum;
    assign req_uport_o  = req.uport;
    assign req_eport_o  = req.eport;
endmodule

// File: rtl/mupd_checker.sv
module mupd_checker #(
    parameter int ACT_W = 32,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [7:0]       rate_i,
    input logic [7:0]       fs_ctrl_i,
    input logic             fail_i,
    input logic [ACT_W-1:0] act_lvl_o,
    input logic             upd_pulse_o,
    input logic [7:0]       force_reg_o,
    input logic             req_reboot_o,
    input logic             req_reenum_o,
    input logic [CNT_W-1:0] fs_count_o
);
    AST_FORCE_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (force_reg_o == 8'h01) |=> (upd_pulse_o && force_reg_o == 8'h00)); // R4

    AST_RATE_ZERO_MANUAL: assert property (@(posedge clk) disable iff (rst)
        upd_pulse_o |-> ($past(force_reg_o) == 8'h01 || $past(rate_i) != 8'h00)); // R3

    AST_RESTART_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(req_reboot_o && req_reenum_o)); // R8

    AST_REBOOT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        req_reboot_o |=> !req_reboot_o); // R8

    AST_FS_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_i) |=> (fs_count_o == $past(fs_count_o) + CNT_W'(1))); // R10

    AST_FS_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
        ($rose(fail_i) && fs_ctrl_i[0]) |=> (act_lvl_o == '0)); // R7
endmodule

bind motor_update_sched mupd_checker #(.ACT_W(NUM_CH*LVL_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rate_i       (rate_i),
    .fs_ctrl_i    (fs_ctrl_i),
    .fail_i       (fail_i),
    .act_lvl_o    (act_lvl_o),
    .upd_pulse_o  (upd_pulse_o),
    .force_reg_o  (force_reg_o),
    .req_reboot_o (req_reboot_o),
    .req_reenum_o (req_reenum_o),
    .fs_count_o   (fs_count_o)
);

// File: tb/motor_update_sched_bench.sv
module motor_update_sched_bench;
    localparam int NUM_CH = 4;
    localparam int LVL_W  = 8;
    localparam int CNT_W  = 8;
    localparam int W      = NUM_CH * LVL_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] drv_en = 8'h01;
    logic [7:0] rate = 8'h00;
    logic force_we = 1'b0;
    logic [7:0] force_wd = 8'h00;
    logic [7:0] fs_ctrl = 8'h00;
    logic ms_tick = 1'b0;
    logic fail = 1'b0;
    logic [W-1:0] stage = '0;
    logic [W-1:0] act;
    logic upd;
    logic [7:0] force_rd;
    logic rq_boot, rq_enum, rq_u, rq_e;
    logic [CNT_W-1:0] fcnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] bank_exp = '0;
    logic [CNT_W-1:0] cnt_exp = '0;

    always #5 clk = ~clk;

    motor_update_sched #(.NUM_CH(NUM_CH), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_motor_update_sched (
        .clk(clk), .rst(rst), .drv_en_i(drv_en), .rate_i(rate),
        .force_we_i(force_we), .force_wdata_i(force_wd), .fs_ctrl_i(fs_ctrl),
        .ms_tick_i(ms_tick), .fail_i(fail), .stage_lvl_i(stage),
        .act_lvl_o(act), .upd_pulse_o(upd), .force_reg_o(force_rd),
        .req_reboot_o(rq_boot), .req_reenum_o(rq_enum), .req_uport_o(rq_u),
        .req_eport_o(rq_e), .fs_count_o(fcnt)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int seed);
        logic [W-1:0] p;
        for (int c = 0; c < NUM_CH; c++) p[c*LVL_W +: LVL_W] = LVL_W'(seed * 37 + c * 11 + 1);
        return p;
    endfunction

    task automatic force_load(input logic [W-1:0] p);
        stage = p;
        force_we = 1'b1; force_wd = 8'h01;
        step();
        force_we = 1'b0;
        step();
        bank_exp = p;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 act", act, 0);
        chk("R1 upd", upd, 0);
        chk("R1 force", force_rd, 0);
        chk("R1 count", fcnt, 0);
        chk("R1 reqs", {rq_boot, rq_enum, rq_u, rq_e}, 0);

        // R2 sweep of periods 1..6
        for (int n = 1; n <= 6; n++) begin
            rate = 8'(n);
            step();
            stage = pat(n);
            for (int i = 1; i <= n; i++) begin
                ms_tick = 1'b1; step(); ms_tick = 1'b0;
                if (i == n) bank_exp = stage;
                chk("R2 act at tick", act, bank_exp);
                chk("R2 upd at tick", upd, i == n);
                step();
                chk("R2 idle act", act, bank_exp);
                chk("R2 idle upd", upd, 0);
            end
        end

        // R5 period change restarts count
        rate = 8'd3; step();
        stage = pat(20);
        for (int i = 0; i < 2; i++) begin ms_tick = 1'b1; step(); ms_tick = 1'b0; end
        rate = 8'd4; step();
        for (int i = 1; i <= 4; i++) begin
            ms_tick = 1'b1; step(); ms_tick = 1'b0;
            if (i == 4) bank_exp = stage;
            chk("R5 restart count", upd, i == 4);
            chk("R5 act", act, bank_exp);
        end

        // R3 zero period: ticks do nothing
        rate = 8'd0; step();
        stage = pat(30);
        for (int i = 0; i < 12; i++) begin
            ms_tick = 1'b1; step(); ms_tick = 1'b0;
            chk("R3 no auto act", act, bank_exp);
            chk("R3 no auto upd", upd, 0);
        end

        // R4 force write
        force_we = 1'b1; force_wd = 8'h01; step(); force_we = 1'b0;
        chk("R4 force reads 1", force_rd, 8'h01);
        chk("R4 not yet loaded", act, bank_exp);
        step();
        bank_exp = stage;
        chk("R4 loaded", act, bank_exp);
        chk("R4 pulse", upd, 1);
        chk("R4 self clear", force_rd, 0);
        step();
        chk("R4 pulse single", upd, 0);
        stage = pat(31);
        for (int v = 0; v < 256; v += 17) begin
            if (v == 1) continue;
            force_we = 1'b1; force_wd = 8'(v); step(); force_we = 1'b0;
            chk("R4 other value reg", force_rd, 0);
            step();
            chk("R4 other value act", act, bank_exp);
            chk("R4 other value upd", upd, 0);
        end

        // R6 enable gating
        for (int v = 0; v < 256; v += 15) begin
            drv_en = 8'(v); #1;
            chk("R6 gating", act, (v == 1) ? bank_exp : '0);
        end
        drv_en = 8'h00; step(); step();
        drv_en = 8'h01; #1;
        chk("R6 bank kept", act, bank_exp);

        // R7 R8 R9 R10 failsafe sweep over all control values
        for (int c = 0; c < 32; c++) begin
            force_load(pat(40 + c));
            fs_ctrl = 8'(c);
            fail = 1'b1; step();
            cnt_exp = cnt_exp + 1'b1;
            if (c[0]) bank_exp = '0;
            chk("R7 bank after fail", act, bank_exp);
            chk("R8 reboot", rq_boot, c[2:1] == 2'd1);
            chk("R8 reenum", rq_enum, c[2:1] == 2'd2);
            chk("R9 uport", rq_u, c[3]);
            chk("R9 eport", rq_e, c[4]);
            chk("R10 count", fcnt, cnt_exp);
            step();
            chk("R8 R9 single pulse", {rq_boot, rq_enum, rq_u, rq_e}, 0);
            chk("R10 held level once", fcnt, cnt_exp);
            fail = 1'b0; step();
        end

        // R10 wrap
        fs_ctrl = 8'h00;
        for (int k = 0; k < 240; k++) begin
            fail = 1'b1; step(); fail = 1'b0; step();
            cnt_exp = cnt_exp + 1'b1;
        end
        chk("R10 wrap", fcnt, cnt_exp);

        // R11 zeroing failsafe wins over same-edge update
        force_load(pat(90));
        rate = 8'd1; step();
        stage = pat(91);
        fs_ctrl = 8'h01;
        ms_tick = 1'b1; fail = 1'b1; step(); ms_tick = 1'b0;
        chk("R11 zero wins", act, 0);
        fail = 1'b0; step();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule